// File: doc/BRIEF.md
# Soft-Stepping Channel Gain Controller with Mute

This block governs the gain of one audio channel. Software programs a 7-bit gain code in half-decibel units, a mute request and a stepping mode; the block then walks its applied gain code toward that programmed value one code per qualifying sample strobe. The walk can run at the sample rate or at half of it, or be switched off so that the gain jumps straight to its target on the next strobe. The applied code feeds a later gain multiplier, which is not part of this block.

A mute request first ramps the applied gain down to code 0 at the stepping rate. The effective mute output asserts only once that ramp has finished. When the request is released, mute drops at once and the gain ramps back up. A settled status bit tells software when the applied gain has caught up with the programmed gain. While the channel power bit is low, the block holds the gain at zero with mute asserted.

The control sequencing is a four-state machine. OFF means powered down. LIVE means tracking the programmed gain. DRAIN means ramping down toward mute. SILENT means muted at code 0. The transitions are:
- OFF→LIVE on power-up without a mute request.
- OFF→SILENT on power-up with a mute request.
- LIVE→DRAIN when mute is requested and the gain is above 0.
- LIVE→SILENT when mute is requested and the gain is already 0.
- DRAIN→SILENT when the gain has reached 0.
- DRAIN→LIVE and SILENT→LIVE when the mute request is withdrawn.
- Any state→OFF when power drops.

Top module: `soft_gain_ctrl`

## Requirements
- R1: The gain code counts 0.5 dB per code, with code 0 meaning 0 dB and code 119 meaning 59.5 dB. Any programmed code from 120 to 127 is treated as 119, so the applied code never exceeds 119.
- R2: During and after reset, with power low, the applied gain is 0, mute_o is 1, settled_o is 0 and powered_o is 0.
- R3: With step mode 2'b00, each sample strobe moves the applied gain by exactly one code toward its target.
- R4: With step mode 2'b01, only every second strobe moves the gain by one code. The strobe count starts afresh, with the first strobe not moving the gain, whenever the mode leaves 2'b01 or power is low.
- R5: With step mode 2'b10 or 2'b11, the applied gain takes the full target value on the next sample strobe.
- R6: The applied gain changes only on the clock edge after a sample strobe, and it stops on the target without overshooting.
- R7: A mute request sets the target to 0. mute_o asserts on the edge after the edge at which the applied gain is seen at 0. Withdrawing the request clears mute_o on the next edge, and the gain then ramps back to the programmed target.
- R8: settled_o is 1 exactly when the channel is powered and the applied gain equals the clamped programmed gain.
- R9: With the power input low, the next edge forces the applied gain to 0, mute_o to 1, settled_o to 0 and powered_o to 0. powered_o follows the power input with one edge of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gain_code_i | input | 7 | Programmed gain code, 0.5 dB per code |
| mute_req_i | input | 1 | Mute request |
| step_mode_i | input | 2 | 00 each strobe, 01 every second strobe, 1x jump |
| sample_stb_i | input | 1 | One-cycle audio sample strobe |
| chan_pwr_i | input | 1 | Channel power-up |
| gain_applied_o | output | 7 | Currently applied gain code |
| mute_o | output | 1 | Effective mute |
| settled_o | output | 1 | Applied gain equals programmed gain |
| powered_o | output | 1 | Channel is in a powered state |

## Verification
A wrong state or a lost half-rate phase shows up as an applied gain that moves one strobe too early or too late, or by more than one code. The bench compares the outputs after every edge, so such a slip is caught in the cycle it happens. A state machine stuck in DRAIN or SILENT shows as a mute_o that is wrong within one edge of the applied gain reaching 0 or of the mute request being withdrawn. A clamp fault shows as an applied code above 119, or as settled_o never rising, as soon as the ramp reaches the top.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_LIVE   = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_SILENT = 2'd3
    } sgc_state_e;

    localparam logic [1:0] MODE_EVERY = 2'b00;
    localparam logic [1:0] MODE_ALT   = 2'b01;
endpackage

// File: rtl/sgc_clamp.sv
module sgc_clamp #(
    parameter int GAIN_W   = 7,
    parameter int GAIN_TOP = 119
) (
    input  logic [GAIN_W-1:0] code_i,
    output logic [GAIN_W-1:0] code_o
);
    localparam logic [GAIN_W-1:0] TOP_CODE = GAIN_W'(GAIN_TOP);

    always_comb begin
        if (code_i > TOP_CODE) code_o = TOP_CODE;
        else                   code_o = code_i;
    end
endmodule

// File: rtl/sgc_pacer.sv
module sgc_pacer
    import sgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic [1:0] mode_i,
    input  logic       pwr_i,
    output logic       adv_o,
    output logic       jump_o
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        phase_q <= 1'b0;
        else if (!pwr_i || mode_i != MODE_ALT) phase_q <= 1'b0;
        else if (stb_i)                    phase_q <= ~phase_q;
    end

    always_comb begin
        jump_o = mode_i[1];
        if (mode_i == MODE_ALT) adv_o = stb_i & phase_q;
        else                    adv_o = stb_i;
    end
endmodule

// File: rtl/sgc_ramp.sv
module sgc_ramp
    import sgc_pkg::*;
#(
    parameter int GAIN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_i,
    input  logic              mute_i,
    input  logic [GAIN_W-1:0] prog_i,
    input  logic              adv_i,
    input  logic              jump_i,
    output logic [GAIN_W-1:0] applied_o,
    output logic              mute_o,
    output logic              powered_o
);
    localparam logic [GAIN_W-1:0] ZERO = '0;
    localparam logic [GAIN_W-1:0] ONE  = GAIN_W'(1);

    sgc_state_e        state_q, state_d;
    logic [GAIN_W-1:0] app_q, app_d, target;

    always_comb target = mute_i ? ZERO : prog_i;

    always_comb begin
        state_d = state_q;
        if (!pwr_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = mute_i ? ST_SILENT : ST_LIVE;
                ST_LIVE:   if (mute_i) state_d = (app_q == ZERO) ? ST_SILENT : ST_DRAIN;
                ST_DRAIN:  if (!mute_i) state_d = ST_LIVE;
                           else if (app_q == ZERO) state_d = ST_SILENT;
                ST_SILENT: if (!mute_i) state_d = ST_LIVE;
            endcase
        end
    end

    always_comb begin
        app_d = app_q;
        if (!pwr_i || state_q == ST_OFF) begin
            app_d = ZERO;
        end else if (adv_i) begin
            if (jump_i)              app_d = target;
            else if (app_q < target) app_d = app_q + ONE;
            else if (app_q > target) app_d = app_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            app_q   <= ZERO;
        end else begin
            state_q <= state_d;
            app_q   <= app_d;
        end
    end

    always_comb begin
        applied_o = app_q;
        unique case (state_q)
            ST_OFF:    begin mute_o = 1'b1; powered_o = 1'b0; end
            ST_LIVE:   begin mute_o = 1'b0; powered_o = 1'b1; end
            ST_DRAIN:  begin mute_o = 1'b0; powered_o = 1'b1; end
            ST_SILENT: begin mute_o = 1'b1; powered_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/soft_gain_ctrl.sv
module soft_gain_ctrl #(
    parameter int GAIN_W   = 7,
    parameter int GAIN_TOP = 119
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain_code_i,
    input  logic              mute_req_i,
    input  logic [1:0]        step_mode_i,
    input  logic              sample_stb_i,
    input  logic              chan_pwr_i,
    output logic [GAIN_W-1:0] gain_applied_o,
    output logic              mute_o,
    output logic              settled_o,
    output logic              powered_o
);
    logic [GAIN_W-1:0] prog_clamped;
    logic              adv, jump;

    sgc_clamp #(.GAIN_W(GAIN_W), .GAIN_TOP(GAIN_TOP)) u_clamp (
        .code_i (gain_code_i),
        .code_o (prog_clamped)
    );

    sgc_pacer u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (sample_stb_i),
        .mode_i (step_mode_i),
        .pwr_i  (chan_pwr_i),
        .adv_o  (adv),
        .jump_o (jump)
    );

    sgc_ramp #(.GAIN_W(GAIN_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_i     (chan_pwr_i),
        .mute_i    (mute_req_i),
        .prog_i    (prog_clamped),
        .adv_i     (adv),
        .jump_i    (jump),
        .applied_o (gain_applied_o),
        .mute_o    (mute_o),
        .powered_o (powered_o)
    );

    always_comb settled_o = powered_o && (gain_applied_o == prog_clamped);
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
    parameter int GAIN_W   = 7,
    parameter int GAIN_TOP = 119
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_pwr_i,
    input logic              sample_stb_i,
    input logic [1:0]        step_mode_i,
    input logic [GAIN_W-1:0] gain_applied_o,
    input logic              mute_o,
    input logic              settled_o,
    input logic              powered_o
);
    // R1
    gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_applied_o <= GAIN_W'(GAIN_TOP));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_pwr_i && !step_mode_i[1]) |=>
            (gain_applied_o == $past(gain_applied_o)) ||
            (gain_applied_o == $past(gain_applied_o) + GAIN_W'(1)) ||
            (gain_applied_o == $past(gain_applied_o) - GAIN_W'(1)));

    // R6
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_pwr_i && !sample_stb_i) |=> $stable(gain_applied_o));

    // R9
    powered_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !powered_o |-> (gain_applied_o == '0 && mute_o && !settled_o));

    // R7
    muted_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o && powered_o) |-> gain_applied_o == '0);

    // R9
    power_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_pwr_i |=> !powered_o);
endmodule

bind soft_gain_ctrl sgc_checker #(.GAIN_W(GAIN_W), .GAIN_TOP(GAIN_TOP)) u_chk (.*);

// File: tb/sim_soft_gain_ctrl.sv
`timescale 1ns/1ps
module sim_soft_gain_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] code = 7'd0;
    logic       mute = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       stb = 1'b0;
    logic       pwr = 1'b0;
    logic [6:0] applied;
    logic       mute_o, settled, powered;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // expected-state model: 0 off, 1 live, 2 drain, 3 silent
    int         m_st = 0;
    logic [6:0] m_app = 7'd0;
    bit         m_ph = 0;

    always #10 clk = ~clk;

    soft_gain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .gain_code_i(code), .mute_req_i(mute),
        .step_mode_i(mode), .sample_stb_i(stb), .chan_pwr_i(pwr),
        .gain_applied_o(applied), .mute_o(mute_o), .settled_o(settled),
        .powered_o(powered)
    );

    function automatic logic [6:0] clampv(logic [6:0] c);
        return (c > 7'd119) ? 7'd119 : c;
    endfunction

    task automatic model_edge();
        logic [6:0] tgt;
        bit adv;
        int nst;
        tgt = mute ? 7'd0 : clampv(code);
        adv = (mode == 2'b01) ? (stb && m_ph) : stb;
        nst = m_st;
        if (!pwr) nst = 0;
        else case (m_st)
            0: nst = mute ? 3 : 1;
            1: if (mute) nst = (m_app == 0) ? 3 : 2;
            2: if (!mute) nst = 1; else if (m_app == 0) nst = 3;
            default: if (!mute) nst = 1;
        endcase
        if (!pwr || m_st == 0) m_app = 7'd0;
        else if (adv) begin
            if (mode[1]) m_app = tgt;
            else if (m_app < tgt) m_app = m_app + 7'd1;
            else if (m_app > tgt) m_app = m_app - 7'd1;
        end
        if (!pwr || mode != 2'b01) m_ph = 0;
        else if (stb) m_ph = ~m_ph;
        m_st = nst;
    endtask

    task automatic check(string req);
        bit em, es, ep;
        em = (m_st == 0 || m_st == 3);
        ep = (m_st != 0);
        es = ep && (m_app == clampv(code));
        vectors++;
        if (applied !== m_app || mute_o !== em || settled !== es || powered !== ep) begin
            fails++;
            $display("FAIL %s: gain=%0d mute=%0b settled=%0b powered=%0b expected gain=%0d mute=%0b settled=%0b powered=%0b",
                     req, applied, mute_o, settled, powered, m_app, em, es, ep);
        end
    endtask

    // one cycle: drive at negedge, update model at posedge, compare after it
    task automatic cyc(logic [6:0] c, bit mu, logic [1:0] md, bit s, bit p, string req);
        @(negedge clk);
        code = c; mute = mu; mode = md; stb = s; pwr = p;
        @(posedge clk);
        model_edge();
        #1 check(req);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5a17));
        repeat (3) @(posedge clk);
        #1 check("R2");
        @(negedge clk) rst_n = 1'b1;
        // R2: powered down after reset
        cyc(7'd40, 1'b1, 2'b00, 1'b1, 1'b0, "R2");
        cyc(7'd40, 1'b1, 2'b00, 1'b1, 1'b0, "R2");
        // power up, unmute, jump mode with clamped code (R5, R1)
        cyc(7'd127, 1'b0, 2'b10, 1'b0, 1'b1, "R9");
        cyc(7'd127, 1'b0, 2'b10, 1'b0, 1'b1, "R6");
        cyc(7'd127, 1'b0, 2'b10, 1'b1, 1'b1, "R5");
        cyc(7'd127, 1'b0, 2'b11, 1'b0, 1'b1, "R1");
        // R3: ramp down one code per strobe, to 110
        for (int i = 0; i < 12; i++) cyc(7'd110, 1'b0, 2'b00, 1'b1, 1'b1, "R3");
        // R6: gaps between strobes
        for (int i = 0; i < 8; i++) cyc(7'd114, 1'b0, 2'b00, i[0], 1'b1, "R6");
        // R4: every second strobe
        for (int i = 0; i < 12; i++) cyc(7'd100, 1'b0, 2'b01, 1'b1, 1'b1, "R4");
        // R7: mute drain, then release
        for (int i = 0; i < 8; i++) cyc(7'd5, 1'b0, 2'b10, 1'b1, 1'b1, "R5");
        for (int i = 0; i < 9; i++) cyc(7'd5, 1'b1, 2'b00, 1'b1, 1'b1, "R7");
        for (int i = 0; i < 7; i++) cyc(7'd5, 1'b0, 2'b00, 1'b1, 1'b1, "R7");
        // R8: settled follows programmed code changes
        cyc(7'd6, 1'b0, 2'b00, 1'b0, 1'b1, "R8");
        cyc(7'd6, 1'b0, 2'b00, 1'b1, 1'b1, "R8");
        // R9: power drop mid-ramp
        cyc(7'd90, 1'b0, 2'b00, 1'b1, 1'b1, "R9");
        cyc(7'd90, 1'b0, 2'b00, 1'b1, 1'b0, "R9");
        cyc(7'd90, 1'b0, 2'b00, 1'b1, 1'b0, "R9");
        // power up muted
        cyc(7'd90, 1'b1, 2'b01, 1'b1, 1'b1, "R9");
        cyc(7'd90, 1'b1, 2'b01, 1'b1, 1'b1, "R7");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] c;
            c = (i % 200 < 100) ? code : 7'($urandom_range(0, 127));
            cyc(c, ($urandom_range(0, 15) == 0) ? ~mute : mute,
                2'($urandom_range(0, 3)) & ((i % 400 < 300) ? 2'b01 : 2'b11),
                1'($urandom_range(0, 2) != 0),
                ($urandom_range(0, 199) == 0) ? 1'b0 : 1'b1, "R6");
        end
        done = 1;
        finish_run();
    end
endmodule